// File: doc/BRIEF.md
# Command-Byte Register Access Controller

This block sits behind the bit-level state machine of a two-wire serial target and turns framed bytes into register accesses. The bit layer reports a start (or repeated start) addressed to this target, each byte the host writes, each byte the host wants to read, and the stop. The first byte written after a start may be a command: when its top bit is set it carries a transfer mode and a 5-bit field that is either a register pointer or a special-function code. Every other written byte is data, stored at the pointer. Every read returns the byte at the pointer. In increment mode the pointer advances after each data access, and in same-register mode it stays put.

The block owns the writable control registers of a light-sensor style front end and drives their values out as plain ports. These are a run/enable byte, an integration time, a wait time, a 16-bit low and a 16-bit high threshold, a persistence byte, a configuration byte and a gain byte. It also returns a fixed identity byte, a live status byte and four 16-bit channel results. To keep a 16-bit result coherent, reading a channel's low byte captures that channel's high byte into a shadow, and the following high-byte read of the same channel returns the captured value. A special function produces a one-cycle interrupt-clear pulse for the interrupt logic.

Top module: `ctlfe_top`

## Requirements
- R1: After reset, `ctl_integ` and `ctl_wait` read 0xFF, every other control output, `rd_data` and `int_clear` read 0x00 / 0.
- R2: The first byte written after `bus_start` is a command when bit 7 is 1. Bits 6:5 give the mode (00 same register, 01 increment) and bits 4:0 become the pointer. A command byte writes no register.
- R3: In same-register mode, successive data writes and reads all address the pointer without changing it.
- R4: In increment mode the pointer rises by one after each data write or read, and wraps from 0x1F to 0x00.
- R5: A command byte with bits 6:5 = 11 and bits 4:0 = 00110 (byte 0xE6) raises `int_clear` for exactly the one cycle after that byte. Any other code in this mode produces no pulse. The pointer and mode are left unchanged in both cases.
- R6: A command byte with bits 6:5 = 10 is ignored: no register write, no pulse, pointer and mode unchanged.
- R7: A first byte with bit 7 clear is stored as data at the current pointer, and the current mode applies.
- R8: Pointer and mode persist across stop and start, so a read with no command uses the last stored pointer.
- R9: A read of a channel low byte (channel k at 0x14+2k) captures that channel's high byte (0x15+2k). The next read of that high byte returns the captured value even if the channel result has changed meanwhile, and it consumes the capture.
- R10: A high-byte read of a channel with no pending capture for that channel returns the live high byte.
- R11: Writes to 0x12..0x1B and to unused addresses (0x02, 0x08..0x0B, 0x0E, 0x10, 0x11, 0x1C..0x1F) change nothing. Reads of unused addresses return 0x00.
- R12: Writable registers read back their stored value, 0x12 returns the identity byte and 0x13 returns `status_in`. The register map is 0x00 run, 0x01 integration, 0x03 wait, 0x04/0x05 low threshold low/high byte, 0x06/0x07 high threshold low/high byte, 0x0C persistence, 0x0D configuration and 0x0F gain.
- R13: `rd_data` changes only in the cycle after a read request and holds its value otherwise. Control outputs change in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start or repeated start addressed to this target |
| bus_stop | input | 1 | Stop condition |
| wr_en | input | 1 | Host wrote a byte |
| wr_byte | input | 8 | Byte written by the host |
| rd_en | input | 1 | Host requests the next read byte |
| rd_data | output | 8 | Read byte, valid the cycle after `rd_en` |
| int_clear | output | 1 | One-cycle interrupt-clear pulse |
| status_in | input | 8 | Live status byte returned at 0x13 |
| ch_data | input | NUM_CH*16 | Channel results, channel k in bits k*16+15:k*16 |
| ctl_enable | output | 8 | Run/enable register |
| ctl_integ | output | 8 | Integration time register |
| ctl_wait | output | 8 | Wait time register |
| thr_low | output | 16 | Low threshold |
| thr_high | output | 16 | High threshold |
| ctl_persist | output | 8 | Persistence register |
| ctl_config | output | 8 | Configuration register |
| ctl_gain | output | 8 | Gain register |

## Verification
The bench uses the default build: four channels based at 0x14, identity 0x5A and clear code 00110. With these values the channel pairs fill 0x14..0x1B and the 5-bit pointer spans the whole 32-address space. The wrap from 0x1F to 0x00 can then be driven in increment mode for both reads and writes, and a burst can sweep every read-only and unused address. With four channels, interleaved low and high reads of different channels test whether a capture is tied to its own channel.

// File: rtl/ctlfe_pkg.sv
package ctlfe_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 5;
    localparam int NREG   = 1 << PTR_W;

    // Register addresses whose meaning neighbours decode
    localparam logic [PTR_W-1:0] A_RUN   = 5'h00;
    localparam logic [PTR_W-1:0] A_INTEG = 5'h01;
    localparam logic [PTR_W-1:0] A_WAIT  = 5'h03;
    localparam logic [PTR_W-1:0] A_TLO_L = 5'h04;
    localparam logic [PTR_W-1:0] A_TLO_H = 5'h05;
    localparam logic [PTR_W-1:0] A_THI_L = 5'h06;
    localparam logic [PTR_W-1:0] A_THI_H = 5'h07;
    localparam logic [PTR_W-1:0] A_PERS  = 5'h0C;
    localparam logic [PTR_W-1:0] A_CFG   = 5'h0D;
    localparam logic [PTR_W-1:0] A_GAIN  = 5'h0F;
    localparam logic [PTR_W-1:0] A_IDENT = 5'h12;
    localparam logic [PTR_W-1:0] A_STAT  = 5'h13;

    typedef enum logic [1:0] {
        XM_SAME    = 2'b00,
        XM_INCR    = 2'b01,
        XM_RSVD    = 2'b10,
        XM_SPECIAL = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ACT_DATA  = 2'd0,
        ACT_POINT = 2'd1,
        ACT_CLEAR = 2'd2,
        ACT_NONE  = 2'd3
    } byte_act_e;

    typedef struct packed {
        byte_act_e        act;
        logic [PTR_W-1:0] ptr;
        logic             incr;
    } cmd_dec_s;

endpackage

// File: rtl/ctlfe_cmd_decode.sv
module ctlfe_cmd_decode
    import ctlfe_pkg::*;
#(
    parameter logic [PTR_W-1:0] CLEAR_CODE = 5'b00110
) (
    input  logic              first,
    input  logic [BYTE_W-1:0] byte_in,
    output cmd_dec_s          dec
);

    xfer_mode_e mode;

    always_comb begin
        mode     = xfer_mode_e'(byte_in[6:5]);
        dec.act  = ACT_DATA;
        dec.ptr  = byte_in[PTR_W-1:0];
        dec.incr = (mode == XM_INCR);
        if (first && byte_in[7]) begin
            case (mode)
                XM_SAME, XM_INCR: dec.act = ACT_POINT;
                XM_SPECIAL:       dec.act = (byte_in[PTR_W-1:0] == CLEAR_CODE) ? ACT_CLEAR : ACT_NONE;
                default:          dec.act = ACT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ctlfe_regbank.sv
module ctlfe_regbank
    import ctlfe_pkg::*;
#(
    parameter logic [NREG-1:0] WR_MASK = 32'h0000_B0FB,
    parameter logic [NREG-1:0] HI_MASK = 32'h0000_000A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic              ctl_hit,
    output logic [BYTE_W-1:0] ctl_rdata,
    output logic [NREG-1:0][BYTE_W-1:0] regs
);

    function automatic logic [NREG-1:0][BYTE_W-1:0] rst_image();
        logic [NREG-1:0][BYTE_W-1:0] img;
        for (int i = 0; i < NREG; i++) begin
            img[i] = (WR_MASK[i] && HI_MASK[i]) ? {BYTE_W{1'b1}} : '0;
        end
        return img;
    endfunction

    localparam logic [NREG-1:0][BYTE_W-1:0] RST_IMG = rst_image();

    logic [NREG-1:0][BYTE_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && WR_MASK[waddr]) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RST_IMG;
        else        regs_q <= regs_d;
    end

    assign ctl_hit   = WR_MASK[raddr];
    assign ctl_rdata = WR_MASK[raddr] ? regs_q[raddr] : '0;
    assign regs      = regs_q;

    // R11: a write aimed at a protected or unused slot leaves storage alone
    a_r11_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !WR_MASK[waddr]) |=> (regs_q == $past(regs_q)));

    // R12: a write to a writable slot is visible on the next cycle
    a_r12_store: assert property (@(posedge clk) disable iff (!rst_n)
        (we && WR_MASK[waddr]) |=> (regs_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/ctlfe_read_path.sv
module ctlfe_read_path
    import ctlfe_pkg::*;
#(
    parameter int                NUM_CH    = 4,
    parameter logic [PTR_W-1:0]  CH_BASE   = 5'h14,
    parameter logic [BYTE_W-1:0] DEVICE_ID = 8'h5A
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_go,
    input  logic [PTR_W-1:0]           addr,
    input  logic                       ctl_hit,
    input  logic [BYTE_W-1:0]          ctl_rdata,
    input  logic [BYTE_W-1:0]          status_in,
    input  logic [NUM_CH*2*BYTE_W-1:0] ch_data,
    output logic [BYTE_W-1:0]          rd_data
);

    localparam int CH_W  = 2 * BYTE_W;
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] shadow;
        logic [IDX_W-1:0]  sh_ch;
        logic              armed;
    } rp_state_s;

    rp_state_s st_d, st_q;

    logic [NUM_CH-1:0]              lo_hit, hi_hit;
    logic [NUM_CH-1:0][BYTE_W-1:0]  lo_byte, hi_byte;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam logic [PTR_W-1:0] LO_A = CH_BASE + PTR_W'(2 * k);
        localparam logic [PTR_W-1:0] HI_A = CH_BASE + PTR_W'(2 * k + 1);
        assign lo_hit[k]  = (addr == LO_A);
        assign hi_hit[k]  = (addr == HI_A);
        assign lo_byte[k] = ch_data[k*CH_W +: BYTE_W];
        assign hi_byte[k] = ch_data[k*CH_W + BYTE_W +: BYTE_W];
    end

    logic [BYTE_W-1:0] sel;
    logic              shadow_use;

    always_comb begin
        sel        = ctl_hit ? ctl_rdata : '0;
        shadow_use = 1'b0;
        if (addr == A_IDENT) sel = DEVICE_ID;
        if (addr == A_STAT)  sel = status_in;
        for (int k = 0; k < NUM_CH; k++) begin
            if (lo_hit[k]) sel = lo_byte[k];
            if (hi_hit[k]) begin
                if (st_q.armed && st_q.sh_ch == IDX_W'(k)) begin
                    sel        = st_q.shadow;
                    shadow_use = 1'b1;
                end else begin
                    sel = hi_byte[k];
                end
            end
        end

        st_d = st_q;
        if (rd_go) begin
            st_d.data = sel;
            if (shadow_use) st_d.armed = 1'b0;
            for (int k = 0; k < NUM_CH; k++) begin
                if (lo_hit[k]) begin
                    st_d.shadow = hi_byte[k];
                    st_d.sh_ch  = IDX_W'(k);
                    st_d.armed  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;

    // R13: the read byte only moves on a read request
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));

    // R9: a pending capture for the addressed channel is what gets returned
    a_r9_shadow_out: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && st_q.armed && hi_hit[st_q.sh_ch]) |=> (rd_data == $past(st_q.shadow)));

    // R9: a consumed capture is not served twice
    a_r9_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && st_q.armed && hi_hit[st_q.sh_ch] && (lo_hit == '0)) |=> !st_q.armed);

endmodule

// File: rtl/ctlfe_top.sv
module ctlfe_top
    import ctlfe_pkg::*;
#(
    parameter int                NUM_CH     = 4,
    parameter logic [PTR_W-1:0]  CH_BASE    = 5'h14,
    parameter logic [BYTE_W-1:0] DEVICE_ID  = 8'h5A,
    parameter logic [PTR_W-1:0]  CLEAR_CODE = 5'b00110
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_start,
    input  logic                       bus_stop,
    input  logic                       wr_en,
    input  logic [7:0]                 wr_byte,
    input  logic                       rd_en,
    output logic [7:0]                 rd_data,
    output logic                       int_clear,
    input  logic [7:0]                 status_in,
    input  logic [NUM_CH*16-1:0]       ch_data,
    output logic [7:0]                 ctl_enable,
    output logic [7:0]                 ctl_integ,
    output logic [7:0]                 ctl_wait,
    output logic [15:0]                thr_low,
    output logic [15:0]                thr_high,
    output logic [7:0]                 ctl_persist,
    output logic [7:0]                 ctl_config,
    output logic [7:0]                 ctl_gain
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             incr;
        logic             first;
        logic             clr;
    } fe_state_s;

    fe_state_s st_d, st_q;
    cmd_dec_s  dec;
    logic      rf_we;
    logic      rd_go;
    logic      ctl_hit;
    logic [BYTE_W-1:0] ctl_rdata;
    logic [NREG-1:0][BYTE_W-1:0] regs;

    ctlfe_cmd_decode #(.CLEAR_CODE(CLEAR_CODE)) u_dec (
        .first   (st_q.first),
        .byte_in (wr_byte),
        .dec     (dec)
    );

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        rf_we    = 1'b0;
        rd_go    = 1'b0;
        if (bus_start) begin
            st_d.first = 1'b1;
        end else if (bus_stop) begin
            st_d.first = 1'b0;
        end else if (wr_en) begin
            st_d.first = 1'b0;
            case (dec.act)
                ACT_POINT: begin
                    st_d.ptr  = dec.ptr;
                    st_d.incr = dec.incr;
                end
                ACT_CLEAR: st_d.clr = 1'b1;
                ACT_DATA: begin
                    rf_we = 1'b1;
                    if (st_q.incr) st_d.ptr = st_q.ptr + PTR_W'(1);
                end
                default: ;
            endcase
        end else if (rd_en) begin
            rd_go = 1'b1;
            if (st_q.incr) st_d.ptr = st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ctlfe_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (rf_we),
        .waddr     (st_q.ptr),
        .wdata     (wr_byte),
        .raddr     (st_q.ptr),
        .ctl_hit   (ctl_hit),
        .ctl_rdata (ctl_rdata),
        .regs      (regs)
    );

    ctlfe_read_path #(
        .NUM_CH    (NUM_CH),
        .CH_BASE   (CH_BASE),
        .DEVICE_ID (DEVICE_ID)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_go     (rd_go),
        .addr      (st_q.ptr),
        .ctl_hit   (ctl_hit),
        .ctl_rdata (ctl_rdata),
        .status_in (status_in),
        .ch_data   (ch_data),
        .rd_data   (rd_data)
    );

    assign int_clear   = st_q.clr;
    assign ctl_enable  = regs[A_RUN];
    assign ctl_integ   = regs[A_INTEG];
    assign ctl_wait    = regs[A_WAIT];
    assign thr_low     = {regs[A_TLO_H], regs[A_TLO_L]};
    assign thr_high    = {regs[A_THI_H], regs[A_THI_L]};
    assign ctl_persist = regs[A_PERS];
    assign ctl_config  = regs[A_CFG];
    assign ctl_gain    = regs[A_GAIN];

    // R5: the clear pulse never lasts beyond one cycle
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        int_clear |=> !int_clear);

    // R5: a clear pulse is always caused by the clear command byte
    a_r5_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_clear) |-> ($past(wr_en) && $past(wr_byte) == {3'b111, CLEAR_CODE}));

    // R6: the reserved mode leaves pointer, mode and outputs untouched
    a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bus_start && !bus_stop && st_q.first && wr_byte[7:5] == 3'b110)
        |=> ($stable(st_q.ptr) && $stable(st_q.incr) && !int_clear && $stable(ctl_enable)));

    // R4: increment mode steps the pointer by one on each read, wrapping
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && st_q.incr) |=> (st_q.ptr == $past(st_q.ptr) + PTR_W'(1)));

    // R3: same-register mode keeps the pointer on each read
    a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !st_q.incr) |=> $stable(st_q.ptr));

endmodule

// File: tb/ctlfe_top_tb.sv
`timescale 1ns/100ps
module ctlfe_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic [7:0]  status_in = 8'h00;
    logic [63:0] ch_data = 64'h0;
    logic [7:0]  rd_data;
    logic        int_clear;
    logic [7:0]  ctl_enable, ctl_integ, ctl_wait, ctl_persist, ctl_config, ctl_gain;
    logic [15:0] thr_low, thr_high;

    always #2.5 clk = ~clk;

    ctlfe_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .wr_en(wr_en), .wr_byte(wr_byte), .rd_en(rd_en), .rd_data(rd_data),
        .int_clear(int_clear), .status_in(status_in), .ch_data(ch_data),
        .ctl_enable(ctl_enable), .ctl_integ(ctl_integ), .ctl_wait(ctl_wait),
        .thr_low(thr_low), .thr_high(thr_high), .ctl_persist(ctl_persist),
        .ctl_config(ctl_config), .ctl_gain(ctl_gain)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_mem [0:31];
    integer     m_ptr, m_first, m_incr, m_armed, m_shch;
    logic [7:0] m_shadow, m_rd;
    logic       m_clr;

    function automatic bit writable(input integer a);
        return (a == 0 || a == 1 || a == 3 || (a >= 4 && a <= 7) || a == 12 || a == 13 || a == 15);
    endfunction

    function automatic logic [7:0] hi_of(input integer k);
        return ch_data[k*16+8 +: 8];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_mem[i] = (i == 1 || i == 3) ? 8'hFF : 8'h00;
            m_ptr = 0; m_first = 0; m_incr = 0; m_armed = 0; m_shch = 0;
            m_shadow = 8'h00; m_rd = 8'h00; m_clr = 1'b0;
        end else begin
            m_clr = 1'b0;
            if (bus_start) m_first = 1;
            else if (bus_stop) m_first = 0;
            else if (wr_en) begin
                if (m_first == 1 && wr_byte[7]) begin
                    if (wr_byte[6:5] == 2'b00 || wr_byte[6:5] == 2'b01) begin
                        m_ptr  = wr_byte[4:0];
                        m_incr = (wr_byte[6:5] == 2'b01);
                    end else if (wr_byte[6:5] == 2'b11 && wr_byte[4:0] == 5'd6) begin
                        m_clr = 1'b1;
                    end
                end else begin
                    if (writable(m_ptr)) m_mem[m_ptr] = wr_byte;
                    if (m_incr != 0) m_ptr = (m_ptr + 1) % 32;
                end
                m_first = 0;
            end else if (rd_en) begin
                if (writable(m_ptr))      m_rd = m_mem[m_ptr];
                else if (m_ptr == 18)     m_rd = 8'h5A;
                else if (m_ptr == 19)     m_rd = status_in;
                else if (m_ptr >= 20 && m_ptr <= 27) begin
                    if ((m_ptr - 20) % 2 == 0) begin
                        m_rd     = ch_data[((m_ptr - 20) / 2)*16 +: 8];
                        m_shadow = hi_of((m_ptr - 20) / 2);
                        m_shch   = (m_ptr - 20) / 2;
                        m_armed  = 1;
                    end else if (m_armed != 0 && m_shch == (m_ptr - 21) / 2) begin
                        m_rd    = m_shadow;
                        m_armed = 0;
                    end else begin
                        m_rd = hi_of((m_ptr - 21) / 2);
                    end
                end else m_rd = 8'h00;
                if (m_incr != 0) m_ptr = (m_ptr + 1) % 32;
            end
        end
    end

    // ---------------- comparison every cycle ----------------
    integer vectors = 0, miscompares = 0;
    bit     cmp_en = 1'b0;
    string  tag = "R1";

    task automatic cmp(input string name, input logic [15:0] act, input logic [15:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s got %h expected %h at %0t", tag, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            vectors++;
            cmp("rd_data",     {8'h0, rd_data},     {8'h0, m_rd});
            cmp("int_clear",   {15'h0, int_clear},  {15'h0, m_clr});
            cmp("ctl_enable",  {8'h0, ctl_enable},  {8'h0, m_mem[0]});
            cmp("ctl_integ",   {8'h0, ctl_integ},   {8'h0, m_mem[1]});
            cmp("ctl_wait",    {8'h0, ctl_wait},    {8'h0, m_mem[3]});
            cmp("thr_low",     thr_low,             {m_mem[5], m_mem[4]});
            cmp("thr_high",    thr_high,            {m_mem[7], m_mem[6]});
            cmp("ctl_persist", {8'h0, ctl_persist}, {8'h0, m_mem[12]});
            cmp("ctl_config",  {8'h0, ctl_config},  {8'h0, m_mem[13]});
            cmp("ctl_gain",    {8'h0, ctl_gain},    {8'h0, m_mem[15]});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic op_start(); @(negedge clk); bus_start = 1'b1; @(negedge clk); bus_start = 1'b0; endtask
    task automatic op_stop();  @(negedge clk); bus_stop  = 1'b1; @(negedge clk); bus_stop  = 1'b0; endtask
    task automatic op_wr(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_byte = b; @(negedge clk); wr_en = 1'b0;
    endtask
    task automatic op_rd(); @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; endtask
    task automatic idle(input integer n); repeat (n) @(negedge clk); endtask

    bit done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        repeat (2) @(posedge clk);
        @(negedge clk); cmp_en = 1'b1;
        idle(2);
        rst_n = 1'b1;
        idle(3);

        // R2 / R4: command with increment, then fill 0x00..0x0F
        tag = "R2";
        op_start(); op_wr(8'hA0);
        tag = "R4";
        for (int i = 0; i < 16; i++) op_wr(8'(i * 7 + 3));
        op_stop();

        // R8 / R11 / R12: read with no command continues at 0x10
        tag = "R8";  status_in = 8'h3C;
        op_start(); op_rd();
        tag = "R11"; op_rd();
        tag = "R12"; op_rd(); op_rd();
        op_stop();
        op_start(); op_wr(8'hA0);
        for (int i = 0; i < 16; i++) op_rd();
        op_stop();

        // R3: same-register mode
        tag = "R3";
        op_start(); op_wr(8'h81); op_wr(8'h55); op_wr(8'h66); op_rd(); op_rd(); op_stop();

        // R7: first byte without bit 7 is data
        tag = "R7";
        op_start(); op_wr(8'h23); op_rd(); op_stop();
        op_start(); op_wr(8'hA6); op_stop();
        op_start(); op_wr(8'h19); op_wr(8'h2A); op_stop();
        op_start(); op_wr(8'hA6); op_rd(); op_rd(); op_stop();

        // R5: clear pulse and non-clear special code
        tag = "R5";
        op_start(); op_wr(8'h81); op_stop();
        op_start(); op_wr(8'hE6); idle(2); op_rd(); op_stop();
        op_start(); op_wr(8'hE1); idle(2); op_rd(); op_stop();
        op_start(); op_wr(8'hE0); op_wr(8'h71); op_rd(); op_stop();

        // R6: reserved mode ignored
        tag = "R6";
        op_start(); op_wr(8'hC5); idle(1); op_rd(); op_stop();
        op_start(); op_wr(8'hDF); op_wr(8'h44); op_rd(); op_stop();

        // R9: capture survives a result change
        tag = "R9";
        ch_data = 64'h4444_3333_2222_1111;
        op_start(); op_wr(8'hB4); op_rd();
        ch_data = 64'h4444_3333_2222_99AA;
        op_rd();
        op_rd();
        ch_data = 64'h4444_3333_7788_99AA;
        op_rd();
        op_stop();

        // R10: high read with no matching capture is live
        tag = "R10";
        op_start(); op_wr(8'h95); op_rd(); op_stop();
        op_start(); op_wr(8'h98); op_rd(); op_stop();
        ch_data = 64'hABCD_3333_7788_99AA;
        op_start(); op_wr(8'h9B); op_rd(); op_stop();
        tag = "R9";
        ch_data = 64'hABCD_EF01_7788_99AA;
        op_start(); op_wr(8'h99); op_rd(); op_rd(); op_stop();

        // R11: writes to read-only and unused slots
        tag = "R11";
        op_start(); op_wr(8'hB0);
        for (int i = 0; i < 14; i++) op_wr(8'h99);
        op_stop();
        op_start(); op_wr(8'hA8);
        for (int i = 0; i < 4; i++) op_wr(8'hEE);
        op_stop();
        op_start(); op_wr(8'hA8);
        for (int i = 0; i < 24; i++) op_rd();
        op_stop();

        // R4: wrap 0x1F -> 0x00 for reads and writes
        tag = "R4";
        op_start(); op_wr(8'hBE); op_rd(); op_rd(); op_rd(); op_rd(); op_stop();
        op_start(); op_wr(8'hBF); op_wr(8'h11); op_wr(8'h22); op_wr(8'h33); op_stop();

        // R13: read byte holds while the sources move
        tag = "R13";
        op_start(); op_wr(8'h93); op_rd();
        status_in = 8'hC3; ch_data = 64'h0102_0304_0506_0708;
        idle(6);
        op_rd(); idle(3);
        op_stop();

        // R1: reset again mid-run
        tag = "R1";
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule